// File: doc/BRIEF.md
# Feed-Through Sampling Pulse Generator for Correlated Double Sampling

This block generates the internal pulse that samples the feed-through level of a video signal during correlated double sampling. Each time the data-level sampling strobe arrives, the block counts a programmable delay and then ends the pulse there. The pulse has a fixed width, so its falling edge lands exactly at the end of the delay. The block runs on a clock at twice the master clock rate, which keeps every half-period step synchronous.

The delay is set by a two-bit position code. It is counted in master-clock steps in single-edge mode, and in half-steps in double-edge mode. An eight-bit control register holds the position code, an input-mode bit that enables the pulse only in CDS mode, an output-drive bit that is only reported, and a soft-reset bit. While the soft-reset bit is 0, every other field is held at its default and writes to those fields are ignored.

Top module: `cds_shr_gen`

## Requirements
- R1: After the synchronous reset `rst`, `soft_run`, `drive_dbl`, `cds_mode` and `pos_code` all read 0, and `ft_pulse` is low.
- R2: Bit 7 of a write sets `soft_run`. While `soft_run` is 0, the other fields keep their defaults (0), and a write to them is ignored, including the write that sets bit 7. A write with bit 7 = 0 returns all fields to their defaults on the same edge.
- R3: While `soft_run` is 1, a write loads `drive_dbl` from bit 5, `cds_mode` from bit 4 and `pos_code` from bits 3:2. The new values are visible on the cycle after the write edge. Bit 6 is ignored.
- R4: Without a write, the fields do not change, whatever the strobe or the edge mode does.
- R5: In single-edge mode (`edge_dbl` = 0), the falling edge of `ft_pulse` comes D = 4 + 2·code clock cycles after the edge that captures `strobe`. That is 4, 6, 8 or 10 cycles, which equals 2, 3, 4 or 5 master periods. Taking the cycle after the capture edge as k = 0, the pulse is high exactly in cycles k = D−2 and k = D−1.
- R6: In double-edge mode (`edge_dbl` = 1), D = 2 + code, which is 2, 3, 4 or 5 cycles (1 to 2.5 master periods). The same placement applies.
- R7: Every pulse is high for exactly two cycles, whatever the position code.
- R8: When `cds_mode` is 0, `ft_pulse` stays low and strobes are ignored.
- R9: A strobe that arrives while a delay is still counting restarts the count. Only the pulse of the latest strobe is produced.
- R10: A change to `pos_code` or `edge_dbl` after a strobe does not move that strobe's pulse. The change applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master clock rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| strobe | input | 1 | Data-level sampling strobe, one cycle wide |
| edge_dbl | input | 1 | 0 = single-edge timing, 1 = double-edge timing |
| ft_pulse | output | 1 | Feed-through sampling pulse, active high |
| soft_run | output | 1 | Soft-reset release bit (bit 7) |
| drive_dbl | output | 1 | Output-drive select (bit 5), report only |
| cds_mode | output | 1 | Input mode, 1 = CDS (bit 4) |
| pos_code | output | 2 | Pulse position code (bits 3:2) |

## Verification
A write is captured on one edge, and the bench reads the fields at the falling clock edge that follows. The pulse counter loads on the strobe capture edge, and the pulse register follows the counter in the same cycle. The bench therefore records `ft_pulse` at each falling edge for 16 cycles after a strobe, and compares the whole trace with a mask that has bits D−2 and D−1 set, where D is computed from the code and the mode. Restarts, changes in mid-count and DC mode use the same trace, with a mask shifted to the later strobe or a mask that is all zero.

// File: rtl/cds_shr_pkg.sv
package cds_shr_pkg;

  localparam int REG_W     = 8;
  localparam int RUN_BIT   = 7;
  localparam int DRIVE_BIT = 5;
  localparam int MODE_BIT  = 4;
  localparam int POS_LSB   = 2;
  localparam int POS_W     = 2;

  typedef struct packed {
    logic             run;
    logic             drive_dbl;
    logic             cds;
    logic [POS_W-1:0] pos;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{run: 1'b0, drive_dbl: 1'b0, cds: 1'b0, pos: '0};

endpackage

// File: rtl/cds_ctrl_reg.sv
module cds_ctrl_reg
  import cds_shr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.run = wr_data[RUN_BIT];
    end
    if (!ctrl_q.run || (wr_en && !wr_data[RUN_BIT])) begin
      ctrl_d.drive_dbl = CTRL_DEFAULT.drive_dbl;
      ctrl_d.cds       = CTRL_DEFAULT.cds;
      ctrl_d.pos       = CTRL_DEFAULT.pos;
    end else if (wr_en) begin
      ctrl_d.drive_dbl = wr_data[DRIVE_BIT];
      ctrl_d.cds       = wr_data[MODE_BIT];
      ctrl_d.pos       = wr_data[POS_LSB +: POS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_DEFAULT;
    else     ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/cds_delay_sel.sv
module cds_delay_sel
  import cds_shr_pkg::*;
#(
  parameter int SGL_BASE = 4,
  parameter int SGL_STEP = 2,
  parameter int DBL_BASE = 2,
  parameter int DBL_STEP = 1,
  parameter int CNT_W    = 4
) (
  input  logic [POS_W-1:0] pos,
  input  logic             edge_dbl,
  output logic [CNT_W-1:0] delay
);

  localparam int CODES = 1 << POS_W;

  logic [CNT_W-1:0] sgl_tab [CODES];
  logic [CNT_W-1:0] dbl_tab [CODES];

  for (genvar c = 0; c < CODES; c++) begin : g_tab
    assign sgl_tab[c] = CNT_W'(SGL_BASE + c * SGL_STEP);
    assign dbl_tab[c] = CNT_W'(DBL_BASE + c * DBL_STEP);
  end

  assign delay = edge_dbl ? dbl_tab[pos] : sgl_tab[pos];

endmodule

// File: rtl/cds_pulse_timer.sv
module cds_pulse_timer #(
  parameter int CNT_W    = 4,
  parameter int PULSE_HP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             strobe,
  input  logic [CNT_W-1:0] delay,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    if (!enable)             cnt_d = '0;
    else if (strobe)         cnt_d = delay;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = '0;
    pulse_d = enable && (cnt_d != '0) && (cnt_d <= CNT_W'(PULSE_HP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/cds_shr_gen.sv
module cds_shr_gen
  import cds_shr_pkg::*;
#(
  parameter int SGL_BASE = 4,
  parameter int SGL_STEP = 2,
  parameter int DBL_BASE = 2,
  parameter int DBL_STEP = 1,
  parameter int PULSE_HP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       strobe,
  input  logic       edge_dbl,
  output logic       ft_pulse,
  output logic       soft_run,
  output logic       drive_dbl,
  output logic       cds_mode,
  output logic [1:0] pos_code
);

  localparam int MAX_DLY = SGL_BASE + ((1 << POS_W) - 1) * SGL_STEP;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] delay;
  logic             pulse_raw;

  cds_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  cds_delay_sel #(
    .SGL_BASE (SGL_BASE),
    .SGL_STEP (SGL_STEP),
    .DBL_BASE (DBL_BASE),
    .DBL_STEP (DBL_STEP),
    .CNT_W    (CNT_W)
  ) u_dly (
    .pos      (ctrl.pos),
    .edge_dbl (edge_dbl),
    .delay    (delay)
  );

  cds_pulse_timer #(
    .CNT_W    (CNT_W),
    .PULSE_HP (PULSE_HP)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .enable (ctrl.cds),
    .strobe (strobe),
    .delay  (delay),
    .pulse  (pulse_raw)
  );

  assign ft_pulse  = pulse_raw & ctrl.cds;
  assign soft_run  = ctrl.run;
  assign drive_dbl = ctrl.drive_dbl;
  assign cds_mode  = ctrl.cds;
  assign pos_code  = ctrl.pos;

endmodule

// File: rtl/cds_shr_chk.sv
module cds_shr_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       strobe,
  input logic       edge_dbl,
  input logic       ft_pulse,
  input logic       soft_run,
  input logic       drive_dbl,
  input logic       cds_mode,
  input logic [1:0] pos_code
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!soft_run && !drive_dbl && !cds_mode && pos_code == 2'b00 && !ft_pulse));

  assert_held_default_R2: assert property (@(posedge clk) disable iff (rst)
    !soft_run |-> (!drive_dbl && !cds_mode && pos_code == 2'b00));

  assert_fields_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (soft_run && !wr_en) |=> ($stable(drive_dbl) && $stable(cds_mode) && $stable(pos_code)));

  assert_dc_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !cds_mode |-> !ft_pulse);

  assert_min_width_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ft_pulse) && !wr_en) |=> (ft_pulse || !cds_mode));

  assert_shortest_delay_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && cds_mode && edge_dbl && pos_code == 2'b00 && !wr_en) |=> ft_pulse);

endmodule

bind cds_shr_gen cds_shr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .strobe    (strobe),
  .edge_dbl  (edge_dbl),
  .ft_pulse  (ft_pulse),
  .soft_run  (soft_run),
  .drive_dbl (drive_dbl),
  .cds_mode  (cds_mode),
  .pos_code  (pos_code)
);

// File: tb/test_cds_shr_gen.sv
`timescale 1ns/1ps
module test_cds_shr_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       strobe;
  logic       edge_dbl;
  logic       ft_pulse;
  logic       soft_run;
  logic       drive_dbl;
  logic       cds_mode;
  logic [1:0] pos_code;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cds_shr_gen i_cds_shr_gen (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .strobe    (strobe),
    .edge_dbl  (edge_dbl),
    .ft_pulse  (ft_pulse),
    .soft_run  (soft_run),
    .drive_dbl (drive_dbl),
    .cds_mode  (cds_mode),
    .pos_code  (pos_code)
  );

  function automatic logic [15:0] mask(input int base, input int d);
    logic [15:0] m = '0;
    m[base + d - 2] = 1'b1;
    m[base + d - 1] = 1'b1;
    return m;
  endfunction

  task automatic chk_fields(input string req, input logic r, input logic dr,
                            input logic cm, input logic [1:0] pc);
    tests++;
    if ({soft_run, drive_dbl, cds_mode, pos_code} !== {r, dr, cm, pc}) begin
      fails++;
      $display("FAIL %s fields got run=%b drv=%b cds=%b pos=%b exp run=%b drv=%b cds=%b pos=%b",
               req, soft_run, drive_dbl, cds_mode, pos_code, r, dr, cm, pc);
    end
  endtask

  task automatic chk_trace(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s pulse trace got %b exp %b", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_trace(input int s2, input int wc, input logic [7:0] wd,
                           input bit flip_edge, output logic [15:0] tr);
    strobe = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      tr[k]  = ft_pulse;
      strobe = (k + 1 == s2);
      wr_en  = (k + 1 == wc);
      wr_data = wd;
      if (flip_edge && k == 0) edge_dbl = ~edge_dbl;
    end
    strobe = 1'b0;
    wr_en  = 1'b0;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] tr;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; strobe = 1'b0; edge_dbl = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_fields("R1", 0, 0, 0, 2'b00);
    tests++;
    if (ft_pulse !== 1'b0) begin
      fails++; $display("FAIL R1 ft_pulse got %b exp 0", ft_pulse);
    end

    // R2: writes to other fields ignored while held, even the releasing write
    do_write(8'h3C);
    chk_fields("R2", 0, 0, 0, 2'b00);
    do_write(8'hBC);
    chk_fields("R2", 1, 0, 0, 2'b00);

    // R3: load fields; bit 6 ignored
    do_write(8'hBC);
    chk_fields("R3", 1, 1, 1, 2'b11);
    do_write(8'hD0);
    chk_fields("R3", 1, 0, 1, 2'b00);

    // R2: clearing bit 7 returns defaults on the same edge
    do_write(8'h3C);
    chk_fields("R2", 0, 0, 0, 2'b00);
    do_write(8'h80);

    // R5 / R6 / R7: sweep modes and codes in CDS mode
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        do_write(8'h90 | 8'(c << 2));
        edge_dbl = m[0];
        run_trace(-1, -1, 8'h00, 1'b0, tr);
        if (m == 0) chk_trace($sformatf("R5 R7 code=%0d", c), tr, mask(0, 4 + 2 * c));
        else        chk_trace($sformatf("R6 R7 code=%0d", c), tr, mask(0, 2 + c));
        // R4: strobes and mode input leave fields unchanged
        chk_fields("R4", 1, 0, 1, 2'(c));
      end
    end

    // R8: DC mode, no pulse at any code or mode
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        do_write(8'h80 | 8'(c << 2));
        edge_dbl = m[0];
        run_trace(-1, -1, 8'h00, 1'b0, tr);
        chk_trace($sformatf("R8 mode=%0d code=%0d", m, c), tr, 16'h0000);
      end
    end

    // R9: restart during count (single edge, code 3, D=10; second strobe at k=4)
    do_write(8'h9C);
    edge_dbl = 1'b0;
    run_trace(4, -1, 8'h00, 1'b0, tr);
    chk_trace("R9 restart", tr, mask(4, 10));

    // R9: restart in double edge, code 1 (D=3), second strobe at k=1
    do_write(8'h94);
    edge_dbl = 1'b1;
    run_trace(1, -1, 8'h00, 1'b0, tr);
    chk_trace("R9 restart dbl", tr, mask(1, 3));

    // R10: code change after strobe keeps old delay (single, code 0, D=4)
    do_write(8'h90);
    edge_dbl = 1'b0;
    run_trace(-1, 1, 8'h9C, 1'b0, tr);
    chk_trace("R10 code change", tr, mask(0, 4));
    chk_fields("R10", 1, 0, 1, 2'b11);

    // R10: edge mode change after strobe keeps old delay (single, code 3, D=10)
    edge_dbl = 1'b0;
    run_trace(-1, -1, 8'h00, 1'b1, tr);
    chk_trace("R10 edge change", tr, mask(0, 10));
    // next strobe uses the new double-edge timing: D = 2 + 3
    run_trace(-1, -1, 8'h00, 1'b0, tr);
    chk_trace("R10 new timing", tr, mask(0, 5));

    // R2/R8: soft reset clears mode, then strobes do nothing
    do_write(8'h00);
    chk_fields("R2", 0, 0, 0, 2'b00);
    run_trace(-1, -1, 8'h00, 1'b0, tr);
    chk_trace("R8 after soft reset", tr, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule